// File: doc/BRIEF.md
# Complementary Driver Dead-Time Generator

The block turns one PWM command into two drive signals that are never on together. One drives a main power switch and the other an auxiliary switch, such as a synchronous rectifier or a clamp. The auxiliary switch conducts while the command is low. When the command rises, the auxiliary drive releases at once and the main drive follows after a programmed lead gap. When the command falls, the main drive releases at once and the auxiliary drive returns after a separately programmed trail gap.

Both gaps are counts of clock cycles, read from input buses when the gap starts. Each gap has a synchronous cut input, fed for example from a voltage comparator. Asserting it ends the gap on the next clock edge. The PWM command is asynchronous and passes through a synchronizer before use. The lead cut, trail cut, enable and count inputs are taken to be synchronous to the clock. The enable input gates the main drive low without disturbing the sequencing. A parameter selects the electrical polarity of the auxiliary drive.

Top module: `dead_time_gen`

## Requirements
- R1: During and right after reset, `main_drv` is 0 and `aux_drv` is at its off level. The off level is 0 when AUX_ON_HIGH=1 and 1 when AUX_ON_HIGH=0.
- R2: A change on `pwm_in` takes effect at the outputs on the third rising clock edge after it is set up. Two synchronizer stages come first, then the output registers.
- R3: When the synchronized command is seen high, the auxiliary drive turns off on that edge. `main_drv` turns on exactly `lead_dly` cycles later.
- R4: When the synchronized command is seen low, `main_drv` turns off on that edge. The auxiliary drive turns on exactly `trail_dly` cycles later.
- R5: A count of 0 makes the delayed output change on the same edge as the immediate one.
- R6: If `lead_cut` is high while the lead gap runs, or on the edge where the gap would start, `main_drv` turns on at the next edge.
- R7: If `trail_cut` is high while the trail gap runs, the auxiliary drive turns on at the next edge.
- R8: While `enable` is 0, `main_drv` is 0 with no clock delay. The sequence keeps running, and `main_drv` returns as soon as `enable` goes back to 1 if the main switch is still due on.
- R9: A low command seen while the lead gap runs abandons the gap, and `main_drv` never turns on. This includes the edge on which the gap would have expired. The trail gap then starts.
- R10: A high command seen while the trail gap runs abandons it. The auxiliary drive stays off and the lead gap starts over.
- R11: `main_drv` and the auxiliary drive in its on level are never active in the same cycle.
- R12: AUX_ON_HIGH=0 produces the exact inverse of the `aux_drv` waveform produced by AUX_ON_HIGH=1.
- R13: After reset with the command low, the auxiliary drive stays off until the command has gone high and then low again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwm_in | input | 1 | PWM command, asynchronous |
| enable | input | 1 | 1 allows the main drive; 0 forces it low |
| lead_dly | input | CNT_W | Cycles from auxiliary off to main on |
| trail_dly | input | CNT_W | Cycles from main off to auxiliary on |
| lead_cut | input | 1 | Ends the lead gap at the next edge |
| trail_cut | input | 1 | Ends the trail gap at the next edge |
| main_drv | output | 1 | Main switch drive, active high |
| aux_drv | output | 1 | Auxiliary switch drive; polarity set by AUX_ON_HIGH |

## Verification
Two events can land on the same clock edge: the synchronized falling command, and the last count of the lead gap. That edge decides whether the main switch gets a one-cycle sliver of on-time. The bench drives the fall exactly lead_dly cycles after the rise, so the low level reaches the sequencer on the edge where the gap would expire. It requires `main_drv` to stay 0 throughout. The same pattern shifted one cycle later must give exactly one cycle of `main_drv`, which confirms the edge was placed correctly.

// File: rtl/ddt_pkg.sv
package ddt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_MAIN,
        ST_TRAIL,
        ST_AUX
    } seq_state_e;

    localparam int TMR_LEAD  = 0;
    localparam int TMR_TRAIL = 1;
    localparam int NUM_TMR   = 2;

    typedef struct packed {
        seq_state_e st;
        logic       main_on;
        logic       aux_on;
    } seq_regs_t;

endpackage

// File: rtl/ddt_sync.sv
module ddt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
    } sync_regs_t;

    sync_regs_t sync_d, sync_q;

    always_comb begin
        sync_d.sh = {sync_q.sh[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign q = sync_q.sh[STAGES-1];
endmodule

// File: rtl/ddt_delay_timer.sv
module ddt_delay_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic             cut,
    input  logic [CNT_W-1:0] dly,
    output logic             fire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_regs_t;

    tmr_regs_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        fire  = 1'b0;
        if (abort) begin
            tmr_d.busy = 1'b0;
        end else if (start) begin
            if (dly == '0 || cut) begin
                fire       = 1'b1;
                tmr_d.busy = 1'b0;
            end else begin
                tmr_d.busy = 1'b1;
                tmr_d.cnt  = dly;
            end
        end else if (tmr_q.busy) begin
            if (tmr_q.cnt <= ONE || cut) begin
                fire       = 1'b1;
                tmr_d.busy = 1'b0;
            end else begin
                tmr_d.cnt = tmr_q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    // R6 / R7: a cut during a running gap ends it on the next edge
    assert_cut_ends_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.busy && cut && !abort && !start) |=> !tmr_q.busy);

    // R3 / R4: an undisturbed gap counts down by one per cycle
    assert_count_steps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.busy && !abort && !start && !cut && tmr_q.cnt > ONE)
        |=> (tmr_q.busy && tmr_q.cnt == $past(tmr_q.cnt) - ONE));
endmodule

// File: rtl/ddt_seq.sv
module ddt_seq
    import ddt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lvl,
    input  logic [NUM_TMR-1:0] fire,
    output logic [NUM_TMR-1:0] start,
    output logic [NUM_TMR-1:0] abort,
    output logic               main_q,
    output logic               aux_q
);
    seq_regs_t seq_d, seq_q;
    logic rise_evt, fall_evt;

    always_comb begin
        rise_evt = lvl && (seq_q.st == ST_IDLE || seq_q.st == ST_TRAIL ||
                           seq_q.st == ST_AUX);
        fall_evt = !lvl && (seq_q.st == ST_LEAD || seq_q.st == ST_MAIN);
        start            = '0;
        abort            = '0;
        start[TMR_LEAD]  = rise_evt;
        abort[TMR_TRAIL] = rise_evt;
        start[TMR_TRAIL] = fall_evt;
        abort[TMR_LEAD]  = fall_evt;
    end

    always_comb begin
        seq_d = seq_q;
        if (rise_evt) begin
            seq_d.st = fire[TMR_LEAD] ? ST_MAIN : ST_LEAD;
        end else if (fall_evt) begin
            seq_d.st = fire[TMR_TRAIL] ? ST_AUX : ST_TRAIL;
        end else if (seq_q.st == ST_LEAD && fire[TMR_LEAD]) begin
            seq_d.st = ST_MAIN;
        end else if (seq_q.st == ST_TRAIL && fire[TMR_TRAIL]) begin
            seq_d.st = ST_AUX;
        end
        seq_d.main_on = (seq_d.st == ST_MAIN);
        seq_d.aux_on  = (seq_d.st == ST_AUX);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: ST_IDLE, main_on: 1'b0, aux_on: 1'b0};
        else        seq_q <= seq_d;
    end

    assign main_q = seq_q.main_on;
    assign aux_q  = seq_q.aux_on;

    assert_main_off_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fall_evt |=> !seq_q.main_on);

    assert_aux_off_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rise_evt |=> !seq_q.aux_on);

    assert_main_after_lead_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_q.main_on) |-> $past(seq_q.st == ST_LEAD || rise_evt));

    assert_aux_after_trail_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_q.aux_on) |-> $past(seq_q.st == ST_TRAIL || fall_evt));
endmodule

// File: rtl/dead_time_gen.sv
module dead_time_gen
    import ddt_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter bit AUX_ON_HIGH = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwm_in,
    input  logic             enable,
    input  logic [CNT_W-1:0] lead_dly,
    input  logic [CNT_W-1:0] trail_dly,
    input  logic             lead_cut,
    input  logic             trail_cut,
    output logic             main_drv,
    output logic             aux_drv
);
    localparam int NT = NUM_TMR;

    logic                     pwm_lvl;
    logic [NT-1:0]            tmr_start, tmr_abort, tmr_fire, cut_arr;
    logic [NT-1:0][CNT_W-1:0] dly_arr;
    logic                     main_q, aux_q, aux_on_port;

    assign dly_arr[TMR_LEAD]  = lead_dly;
    assign dly_arr[TMR_TRAIL] = trail_dly;
    assign cut_arr[TMR_LEAD]  = lead_cut;
    assign cut_arr[TMR_TRAIL] = trail_cut;

    ddt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pwm_in),
        .q     (pwm_lvl)
    );

    ddt_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl    (pwm_lvl),
        .fire   (tmr_fire),
        .start  (tmr_start),
        .abort  (tmr_abort),
        .main_q (main_q),
        .aux_q  (aux_q)
    );

    for (genvar g = 0; g < NT; g++) begin : g_tmr
        ddt_delay_timer #(.CNT_W(CNT_W)) u_tmr (
            .clk   (clk),
            .rst_n (rst_n),
            .start (tmr_start[g]),
            .abort (tmr_abort[g]),
            .cut   (cut_arr[g]),
            .dly   (dly_arr[g]),
            .fire  (tmr_fire[g])
        );
    end

    assign main_drv = main_q & enable;

    if (AUX_ON_HIGH) begin : g_aux_hi
        assign aux_drv = aux_q;
    end else begin : g_aux_lo
        assign aux_drv = ~aux_q;
    end

    assign aux_on_port = (aux_drv == AUX_ON_HIGH);

    assert_never_both_on_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(main_drv && aux_on_port));
endmodule

// File: tb/dead_time_gen_tb.sv
module dead_time_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwm_in = 1'b0;
    logic       enable = 1'b1;
    logic [7:0] lead_dly = 8'd4;
    logic [7:0] trail_dly = 8'd3;
    logic       lead_cut = 1'b0;
    logic       trail_cut = 1'b0;
    logic       main_drv, aux_drv, main_inv, aux_inv;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    dead_time_gen dut_i (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .enable(enable),
        .lead_dly(lead_dly), .trail_dly(trail_dly),
        .lead_cut(lead_cut), .trail_cut(trail_cut),
        .main_drv(main_drv), .aux_drv(aux_drv));

    dead_time_gen #(.AUX_ON_HIGH(1'b0)) dut_inv_i (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .enable(enable),
        .lead_dly(lead_dly), .trail_dly(trail_dly),
        .lead_cut(lead_cut), .trail_cut(trail_cut),
        .main_drv(main_inv), .aux_drv(aux_inv));

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // R11 / R12 monitor on every cycle
    int mon_err = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (main_drv && aux_drv) begin
                mon_err++;
                $display("FAIL R11 actual=main1_aux1 expected=not_both t=%0t", $time);
            end
            if (aux_inv !== ~aux_drv) begin
                mon_err++;
                $display("FAIL R12 actual=%b expected=%b t=%0t", aux_inv, ~aux_drv, $time);
            end
        end
    end

    task automatic t_reset;
        rst_n = 1'b0; pwm_in = 1'b0;
        step(2);
        chk("R1 main in reset", main_drv, 1'b0);
        chk("R1 aux in reset", aux_drv, 1'b0);
        chk("R1 inverted aux in reset", aux_inv, 1'b1);
        rst_n = 1'b1;
        step(6);
        chk("R13 aux stays off with low command", aux_drv, 1'b0);
    endtask

    task automatic t_basic;
        lead_dly = 8'd4; trail_dly = 8'd3;
        pwm_in = 1'b1;
        step(6); chk("R3 main still off", main_drv, 1'b0);
        step(1); chk("R3 main on after lead", main_drv, 1'b1);
        pwm_in = 1'b0;
        step(2); chk("R2 main holds before sync", main_drv, 1'b1);
        step(1); chk("R4 main off at once", main_drv, 1'b0);
        chk("R4 aux not yet", aux_drv, 1'b0);
        step(2); chk("R4 aux still off", aux_drv, 1'b0);
        step(1); chk("R4 aux on after trail", aux_drv, 1'b1);
        pwm_in = 1'b1;
        step(2); chk("R2 aux holds before sync", aux_drv, 1'b1);
        step(1); chk("R3 aux off at once", aux_drv, 1'b0);
        step(4); chk("R3 main on again", main_drv, 1'b1);
        pwm_in = 1'b0;
        step(10); chk("R4 aux on at rest", aux_drv, 1'b1);
    endtask

    task automatic t_zero;
        lead_dly = 8'd0; trail_dly = 8'd0;
        pwm_in = 1'b1;
        step(2); chk("R5 aux before edge", aux_drv, 1'b1);
        step(1); chk("R5 aux off", aux_drv, 1'b0);
        chk("R5 main on same edge", main_drv, 1'b1);
        pwm_in = 1'b0;
        step(2); chk("R5 main before edge", main_drv, 1'b1);
        step(1); chk("R5 main off", main_drv, 1'b0);
        chk("R5 aux on same edge", aux_drv, 1'b1);
    endtask

    task automatic t_cut;
        lead_dly = 8'd20; trail_dly = 8'd20;
        pwm_in = 1'b1;
        step(5); chk("R6 main off before cut", main_drv, 1'b0);
        lead_cut = 1'b1;
        step(1); chk("R6 cut starts main", main_drv, 1'b1);
        lead_cut = 1'b0;
        pwm_in = 1'b0;
        step(5); chk("R7 aux off before cut", aux_drv, 1'b0);
        trail_cut = 1'b1;
        step(1); chk("R7 cut starts aux", aux_drv, 1'b1);
        trail_cut = 1'b0;
        lead_cut = 1'b1;
        pwm_in = 1'b1;
        step(3); chk("R6 cut on start edge", main_drv, 1'b1);
        lead_cut = 1'b0;
        trail_dly = 8'd2;
        pwm_in = 1'b0;
        step(10); chk("R4 aux back on", aux_drv, 1'b1);
    endtask

    task automatic t_enable;
        lead_dly = 8'd2; trail_dly = 8'd2;
        pwm_in = 1'b1;
        step(6); chk("R8 main on enabled", main_drv, 1'b1);
        enable = 1'b0;
        #1; chk("R8 main gated at once", main_drv, 1'b0);
        step(3); chk("R8 main held low", main_drv, 1'b0);
        enable = 1'b1;
        #1; chk("R8 main returns", main_drv, 1'b1);
        pwm_in = 1'b0;
        step(10); chk("R8 aux on after", aux_drv, 1'b1);
    endtask

    task automatic t_abort_lead;
        lead_dly = 8'd10; trail_dly = 8'd3;
        pwm_in = 1'b1;
        for (int i = 1; i <= 6; i++) begin
            step(1); chk("R9 main off while lead runs", main_drv, 1'b0);
        end
        pwm_in = 1'b0;
        for (int i = 1; i <= 14; i++) begin
            step(1); chk("R9 main never on", main_drv, 1'b0);
            if (i == 5) chk("R9 aux before trail ends", aux_drv, 1'b0);
            if (i == 6) chk("R9 aux on after trail", aux_drv, 1'b1);
        end
    endtask

    task automatic t_coincide;
        int highs;
        lead_dly = 8'd6; trail_dly = 8'd3;
        pwm_in = 1'b1;
        step(6);
        pwm_in = 1'b0;
        highs = 0;
        for (int i = 1; i <= 14; i++) begin
            step(1); if (main_drv) highs++;
        end
        chk("R9 fall on expiry edge wins", highs != 0, 1'b0);
        pwm_in = 1'b1;
        step(7);
        pwm_in = 1'b0;
        highs = 0;
        for (int i = 1; i <= 14; i++) begin
            step(1); if (main_drv) highs++;
        end
        chk("R9 one edge later gives one cycle", highs == 1, 1'b1);
        chk("R4 aux on after coincide", aux_drv, 1'b1);
    endtask

    task automatic t_abort_trail;
        lead_dly = 8'd3; trail_dly = 8'd10;
        pwm_in = 1'b1;
        step(8); chk("R3 main on", main_drv, 1'b1);
        pwm_in = 1'b0;
        for (int i = 1; i <= 6; i++) begin
            step(1); chk("R10 aux off while trail runs", aux_drv, 1'b0);
        end
        pwm_in = 1'b1;
        for (int i = 1; i <= 12; i++) begin
            step(1); chk("R10 aux stays off", aux_drv, 1'b0);
            if (i == 5) chk("R10 main before new lead ends", main_drv, 1'b0);
            if (i == 6) chk("R10 main on after new lead", main_drv, 1'b1);
        end
    endtask

    task automatic finish_run;
        n_chk++;
        n_err += mon_err;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        step(1);
        t_reset();
        t_basic();
        t_zero();
        t_cut();
        t_enable();
        t_abort_lead();
        t_coincide();
        t_abort_trail();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end
endmodule